// File: doc/BRIEF.md
# I2C Serial Memory Slave

This block puts a 2048 x 8 byte memory on a two-wire I2C bus as a slave device. SCL and SDA are brought onto the system clock through synchronizers. The block finds START and STOP conditions from the sampled lines. It then shifts bytes in and out, one bit per SCL pulse. It never drives SDA high: its only bus output is an enable that pulls the line low.

A transfer opens with a slave address byte. The top nibble of that byte must equal the configured device code. The next three bits carry the high part of the memory address, and the last bit picks read or write. In a write, the second byte gives the low eight address bits. Every byte after that is stored at an internal pointer, which then advances. In a read, bytes stream out from the pointer until the master declines to acknowledge.

A repeated START after a word address gives a random read. A read with no word address carries on from wherever the pointer stopped. A build option makes a reduced-size part: the two top address bits are dropped and the memory is 512 bytes.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts address reception from any state, including mid-transfer. A rising SDA while SCL is high (STOP) returns the block to idle.
- R2: The slave address byte is taken MSB first. Bits 7..4 must equal DEV_CODE (default binary 1010). Bit 0 = 1 selects read and 0 selects write. On a match, the slave pulls SDA low for the whole ninth clock.
- R3: When bits 7..4 do not match, the slave gives no acknowledge. It then leaves SDA released and ignores every byte until the next START.
- R4: In a write, the byte after the slave address is the word address. The pointer becomes {address-byte bits 3..1, word byte}, with bit 3 as A10. The word address is acknowledged.
- R5: Each further write byte is stored at the pointer, and the pointer then increments by one. Every such byte is acknowledged.
- R6: In a read, the byte at the pointer is sent MSB first and the pointer increments. Bytes keep coming for as long as the master acknowledges each one.
- R7: After the master leaves the ninth bit of a read byte high (no acknowledge), the slave drives nothing until a STOP or a START.
- R8: The pointer wraps from the top address to 0, both on writes and on reads.
- R9: Bits 3..1 of a read slave address byte are ignored. A read starts at the current pointer, so a write header followed by a repeated START performs a random read.
- R10: With FULL_SIZE = 0, A10 and A9 are ignored and A8 is kept. The memory then holds 512 bytes, and the pointer wraps from 511 to 0.
- R11: SDA is only ever pulled low. The enable changes only while SCL is low.
- R12: While rst_ni is low and right after it, the block is idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pulls SDA low when 1; the line is released when 0 |

## Verification
Checks built into the design run on every clock. They confirm that a START always lands in address reception and a STOP always lands in idle. They confirm that SDA is never pulled while the slave ignores the bus or waits after a refused read byte. They confirm that the enable moves only while SCL is low, and that a write at the top address wraps the pointer to zero.

Other behaviours need whole transfers on the bus, so only the bench scenarios can show them. These are data integrity through the memory, the address concatenation, and random versus current-address reads. They also include ignored address bits in a read header, a mismatched device code leaving the memory untouched, and the reduced-size part's address folding and wrap.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HI_W   = 3;
  localparam int unsigned FULL_W = HI_W + BYTE_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_HOLD,
    ST_IGNORE
  } st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o,
  output logic [LINES-1:0] prev_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;  // bus idles high
      else         chain <= {chain[STAGES-1:0], d_i[g]};
    end
    assign q_o[g]    = chain[STAGES-1];
    assign prev_o[g] = chain[STAGES];
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic scl_i,
  input  logic scl_prev_i,
  input  logic sda_i,
  input  logic sda_prev_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_held;
  assign scl_held   = scl_i & scl_prev_i;
  assign scl_rise_o = scl_i & ~scl_prev_i;
  assign scl_fall_o = ~scl_i & scl_prev_i;
  assign start_o    = scl_held & sda_prev_i & ~sda_i;
  assign stop_o     = scl_held & ~sda_prev_i & sda_i;
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end
  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_mem_pkg::*;
#(
  parameter int unsigned AW       = 11,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              we_o,
  output logic [AW-1:0]     ptr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              sda_oe_o
);
  localparam logic [AW-1:0] PTR_MAX = '1;
  localparam logic [AW-1:0] PTR_ONE = AW'(1);

  st_e               st, after;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg, txreg;
  logic [AW-1:0]     ptr;
  logic [HI_W-1:0]   hi_q;
  logic              ack_drive, m_ack;
  logic              byte_end;
  logic [FULL_W-1:0] waddr_full;

  assign byte_end   = scl_fall_i && (cnt == 4'd8);
  assign waddr_full = {hi_q, shreg};
  assign we_o       = (st == ST_WDATA) && byte_end;
  assign wdata_o    = shreg;
  assign ptr_o      = ptr;
  assign sda_oe_o   = (st == ST_ACK && ack_drive) || (st == ST_RDATA && !txreg[BYTE_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      after     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      txreg     <= '1;
      ptr       <= '0;
      hi_q      <= '0;
      ack_drive <= 1'b0;
      m_ack     <= 1'b0;
    end else if (start_i) begin
      st        <= ST_DEV;
      cnt       <= '0;
      ack_drive <= 1'b0;
    end else if (stop_i) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      ack_drive <= 1'b0;
    end else begin
      unique case (st)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise_i) begin
            shreg <= {shreg[BYTE_W-2:0], sda_i};
            cnt   <= cnt + 4'd1;
          end else if (byte_end) begin
            cnt <= '0;
            if (st == ST_DEV) begin
              if (shreg[7:4] == DEV_CODE) begin
                st        <= ST_ACK;
                ack_drive <= 1'b1;
                if (shreg[0]) after <= ST_RDATA;
                else begin
                  after <= ST_WADDR;
                  hi_q  <= shreg[3:1];
                end
              end else begin
                st <= ST_IGNORE;
              end
            end else if (st == ST_WADDR) begin
              ptr       <= waddr_full[AW-1:0];
              st        <= ST_ACK;
              ack_drive <= 1'b1;
              after     <= ST_WDATA;
            end else begin
              ptr       <= ptr + PTR_ONE;
              st        <= ST_ACK;
              ack_drive <= 1'b1;
              after     <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            ack_drive <= 1'b0;
            st        <= after;
            cnt       <= '0;
            if (after == ST_RDATA) begin
              txreg <= rdata_i;
              ptr   <= ptr + PTR_ONE;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) cnt <= cnt + 4'd1;
          else if (scl_fall_i) begin
            if (cnt == 4'd8) begin
              st    <= ST_RACK;
              cnt   <= '0;
              txreg <= '1;
            end else begin
              txreg <= {txreg[BYTE_W-2:0], 1'b1};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) m_ack <= ~sda_i;
          else if (scl_fall_i) begin
            if (m_ack) begin
              txreg <= rdata_i;
              ptr   <= ptr + PTR_ONE;
              st    <= ST_RDATA;
              cnt   <= '0;
            end else begin
              st <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  start_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st == ST_DEV && cnt == 4'd0));
  // R1
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> st == ST_IDLE);
  // R3
  ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_IGNORE |-> !sda_oe_o);
  // R7
  hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_HOLD |-> !sda_oe_o);
  // R8
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && ptr == PTR_MAX && !start_i && !stop_i) |=> ptr == '0);
  // R11
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [3:0]  DEV_CODE    = 4'b1010,
  parameter bit          FULL_SIZE   = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int unsigned AW = FULL_SIZE ? FULL_W : FULL_W - 2;

  logic [1:0]        lvl, prev;
  logic              scl_rise, scl_fall, start, stop, we;
  logic [AW-1:0]     ptr;
  logic [BYTE_W-1:0] wdata, rdata;

  i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sda_i, scl_i}),
    .q_o    (lvl),
    .prev_o (prev)
  );

  i2c_cond_detect u_cond (
    .scl_i      (lvl[0]),
    .scl_prev_i (prev[0]),
    .sda_i      (lvl[1]),
    .sda_prev_i (prev[1]),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_slave_ctrl #(.AW(AW), .DEV_CODE(DEV_CODE)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (lvl[0]),
    .sda_i      (lvl[1]),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .rdata_i    (rdata),
    .we_o       (we),
    .ptr_o      (ptr),
    .wdata_o    (wdata),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_mem_array #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (ptr),
    .wdata_i (wdata),
    .raddr_i (ptr),
    .rdata_o (rdata)
  );
endmodule

// File: tb/i2c_mem_slave_test.sv
module i2c_mem_slave_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic oe_a, oe_b;
  wire  sda_bus = m_sda & ~oe_a & ~oe_b;

  always #10 clk = ~clk;

  i2c_mem_slave #(.DEV_CODE(4'b1010), .FULL_SIZE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(oe_a));
  i2c_mem_slave #(.DEV_CODE(4'b1011), .FULL_SIZE(1'b0)) uut_small (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(oe_b));

  int checks = 0, errors = 0, r11_viol = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] rx_byte;
  event       rx_ev;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin : monitor
    logic [7:0] e;
    string t;
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) chk(1'b0, "SB empty", {8'h0, rx_byte}, 16'h0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rx_byte == e, t, {8'h0, rx_byte}, {8'h0, e});
      end
    end
  end

  // R11: enable must not move while SCL is high
  logic oe_prev_a = 1'b0, oe_prev_b = 1'b0;
  always @(negedge clk) begin
    if (rst_ni && m_scl && (oe_a != oe_prev_a || oe_b != oe_prev_b)) r11_viol++;
    oe_prev_a <= oe_a;
    oe_prev_b <= oe_b;
  end

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q();
  endtask

  task automatic wbit(input logic b);
    m_sda = b; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
  endtask

  task automatic rbit(output logic b);
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); b = sda_bus; q(); m_scl = 1'b0; q();
  endtask

  task automatic send(input logic [7:0] d, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = !a;
  endtask

  task automatic send_chk(input logic [7:0] d, input bit exp_ack, input string req);
    bit ack;
    send(d, ack);
    chk(ack == exp_ack, req, {15'h0, ack}, {15'h0, exp_ack});
  endtask

  task automatic recv(input bit do_ack);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(!do_ack);
    rx_byte = d;
    ->rx_ev;
    @(negedge clk);
  endtask

  task automatic expect_byte(input logic [7:0] d, input string req);
    exp_q.push_back(d);
    tag_q.push_back(req);
  endtask

  task automatic hdr(input logic [3:0] code, input logic [2:0] hi, input logic [7:0] a);
    i2c_start();
    send_chk({code, hi, 1'b0}, 1'b1, "R2 write header ack");
    send_chk(a, 1'b1, "R4 word address ack");
  endtask

  initial begin : main
    // R12 reset state
    repeat (5) @(negedge clk);
    chk(!oe_a && !oe_b, "R12 in reset", {15'h0, oe_a | oe_b}, 16'h0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(!oe_a && !oe_b, "R12 after reset", {15'h0, oe_a | oe_b}, 16'h0);

    // R4 R5: write five bytes from 0x3FE
    hdr(4'b1010, 3'd3, 8'hFE);
    send_chk(8'h11, 1'b1, "R5 data ack");
    send_chk(8'h22, 1'b1, "R5 data ack");
    send_chk(8'h33, 1'b1, "R5 data ack");
    send_chk(8'h44, 1'b1, "R5 data ack");
    send_chk(8'h55, 1'b1, "R5 data ack");
    i2c_stop();

    // R6 R9: random read from 0x3FF, header read bits 3..1 = 0 ignored
    hdr(4'b1010, 3'd3, 8'hFF);
    i2c_start();
    send_chk(8'b1010_000_1, 1'b1, "R2 read header ack");
    expect_byte(8'h22, "R6 read 0x3FF");
    expect_byte(8'h33, "R6 read 0x400");
    expect_byte(8'h44, "R6 read 0x401");
    recv(1'b1); recv(1'b1); recv(1'b0);
    i2c_stop();

    // R9 current address read, then R7 quiet after no-ack
    i2c_start();
    send_chk(8'b1010_111_1, 1'b1, "R2 read header ack");
    expect_byte(8'h55, "R9 current address 0x402");
    expect_byte(8'hFF, "R7 released after no-ack");
    recv(1'b0); recv(1'b0);
    i2c_stop();

    // R8 wrap on write and read
    hdr(4'b1010, 3'd7, 8'hFF);
    send_chk(8'hA5, 1'b1, "R5 data ack at top");
    send_chk(8'h5A, 1'b1, "R8 data ack after wrap");
    i2c_stop();
    hdr(4'b1010, 3'd7, 8'hFF);
    i2c_start();
    send_chk(8'b1010_000_1, 1'b1, "R2 read header ack");
    expect_byte(8'hA5, "R6 read 0x7FF");
    expect_byte(8'h5A, "R8 read wrapped 0x000");
    recv(1'b1); recv(1'b0);
    i2c_stop();

    // R3 mismatched device code, following bytes ignored
    i2c_start();
    send_chk(8'b0110_000_0, 1'b0, "R3 no ack on mismatch");
    send_chk(8'h00, 1'b0, "R3 ignored byte");
    send_chk(8'hC3, 1'b0, "R3 ignored byte");
    i2c_stop();
    hdr(4'b1010, 3'd0, 8'h00);
    i2c_start();
    send_chk(8'b1010_000_1, 1'b1, "R2 read header ack");
    expect_byte(8'h5A, "R3 memory untouched");
    recv(1'b0);
    i2c_stop();

    // R1: STOP after word address keeps pointer; START aborts a half byte
    hdr(4'b1010, 3'd0, 8'h10);
    send_chk(8'h77, 1'b1, "R5 data ack");
    i2c_stop();
    hdr(4'b1010, 3'd0, 8'h10);
    for (int i = 0; i < 4; i++) wbit(1'b0);
    i2c_start();
    send_chk(8'b1010_000_1, 1'b1, "R1 header after restart");
    expect_byte(8'h77, "R1 restart mid-byte");
    recv(1'b0);
    i2c_stop();
    hdr(4'b1010, 3'd0, 8'h10);
    i2c_stop();
    i2c_start();
    send_chk(8'b1010_000_1, 1'b1, "R2 read header ack");
    expect_byte(8'h77, "R1 stop then current read");
    recv(1'b0);
    i2c_stop();

    // R10 reduced part: A10,A9 dropped, A8 kept, wrap at 511
    hdr(4'b1011, 3'd7, 8'h10);
    send_chk(8'hD1, 1'b1, "R10 data ack");
    i2c_stop();
    hdr(4'b1011, 3'd1, 8'h10);
    i2c_start();
    send_chk(8'b1011_000_1, 1'b1, "R10 read header ack");
    expect_byte(8'hD1, "R10 A10 A9 ignored");
    recv(1'b0);
    i2c_stop();
    hdr(4'b1011, 3'd1, 8'hFF);
    send_chk(8'hE1, 1'b1, "R10 data ack");
    send_chk(8'hE2, 1'b1, "R10 data ack");
    i2c_stop();
    hdr(4'b1011, 3'd6, 8'h00);
    i2c_start();
    send_chk(8'b1011_000_1, 1'b1, "R10 read header ack");
    expect_byte(8'hE2, "R10 wrap 511 to 0");
    recv(1'b0);
    i2c_stop();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "SB drained", 16'(exp_q.size()), 16'h0);
    chk(r11_viol == 0, "R11 enable moved with SCL high", 16'(r11_viol), 16'h0);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule